// File: doc/BRIEF.md
# Branch Condition Evaluator

This combinational unit decides whether a conditional branch is taken and supplies the address of the next instruction. It takes a 4-bit condition code, the four arithmetic flags (zero, sign, overflow, carry), the address of the branch instruction and a 9-bit signed displacement. It drives a taken indication and the next fetch address: the branch target when taken, the following 16-bit instruction when not.

Eight base tests are defined on the low three bits of the code. The fourth code bit inverts the chosen base test, so the upper eight codes are the exact complements of the lower eight. This gives an always-taken code and a never-taken code. The flags come from elsewhere, and the program counter register belongs to the fetch logic that uses `next_pc`.

Top module: `branch_cond_eval`

## Requirements
- R1: With cond_code 0, taken equals the overflow flag. The flags bus is laid out as bit 0 zero, bit 1 sign, bit 2 overflow, bit 3 carry.
- R2: With cond_code 1, taken equals the carry flag.
- R3: With cond_code 2, taken equals the zero flag.
- R4: With cond_code 3, taken is carry OR zero.
- R5: With cond_code 4, taken equals the sign flag.
- R6: With cond_code 5, taken is 1 for every flag value.
- R7: With cond_code 6, taken is overflow OR sign.
- R8: With cond_code 7, taken is (overflow XOR sign) OR zero.
- R9: For cond_code 8 to 15, taken is the inverse of the result for cond_code minus 8. Code 13 is therefore never taken.
- R10: When taken, next_pc is cur_pc plus the displacement read as a 9-bit two's-complement value and sign-extended, computed modulo 2^32.
- R11: When taken, bit 0 of next_pc is 0 whatever cur_pc and disp hold.
- R12: When not taken, next_pc is cur_pc plus 2, computed modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cond_code | input | 4 | Branch condition; bit 3 inverts the base test |
| flags | input | 4 | {carry, overflow, sign, zero} |
| cur_pc | input | 32 | Address of the branch instruction |
| disp | input | 9 | Signed branch displacement in bytes |
| taken | output | 1 | Branch condition holds |
| next_pc | output | 32 | Target when taken, cur_pc + 2 otherwise |

## Verification
The block holds no state, so any fault shows in the same evaluation as the inputs that expose it. A wrong entry in the base-condition vector makes taken wrong for exactly the flag values where that entry differs, and the sweep of every code against all sixteen flag values covers each of them. A bad sign-extension or a missing bit-0 clear shows up only for negative or odd displacements, so the sweep covers all 512 displacements, including a base address near the top of the address space where the sum wraps.

// File: rtl/bce_pkg.sv
// Package: shared widths and flag bit positions for the branch condition evaluator.
// Assumes: the flags bus is {carry, overflow, sign, zero}, with zero at bit 0.
package bce_pkg;
    localparam int ADDR_W      = 32;
    localparam int DISP_W      = 9;
    localparam int CODE_W      = 4;
    localparam int INSTR_BYTES = 2;

    localparam int FLAG_Z  = 0;
    localparam int FLAG_S  = 1;
    localparam int FLAG_OV = 2;
    localparam int FLAG_CY = 3;
    localparam int FLAG_W  = 4;
endpackage

// File: rtl/bce_cond_eval.sv
// Module: bce_cond_eval
// Evaluates the condition code against the flags. The low code bits pick one
// of the base tests and the top code bit inverts the result.
// Assumes: the flag bit positions come from bce_pkg.
module bce_cond_eval
    import bce_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic [CW-1:0]     code,
    input  logic [FLAG_W-1:0] flg,
    output logic              hit
);
    localparam int SEL_W  = CW - 1;
    localparam int N_BASE = 1 << SEL_W;

    logic z, s, ov, cy;
    logic [N_BASE-1:0] base;

    // Separate the flags into named bits.
    always_comb begin
        z  = flg[FLAG_Z];
        s  = flg[FLAG_S];
        ov = flg[FLAG_OV];
        cy = flg[FLAG_CY];
    end

    // Build the eight base tests in code order.
    always_comb begin
        base    = '0;
        base[0] = ov;
        base[1] = cy;
        base[2] = z;
        base[3] = cy | z;
        base[4] = s;
        base[5] = 1'b1;
        base[6] = ov | s;
        base[7] = (ov ^ s) | z;
    end

    // Select the base test, then invert it for the upper half of the codes.
    always_comb begin
        hit = base[code[SEL_W-1:0]] ^ code[CW-1];
    end

    // Check the always-taken and never-taken codes against the selected result.
    always_comb begin
        if (code == CW'(5)) AST_ALWAYS_TAKEN: assert (hit) else $error("always code not taken"); // R6
        if (code == CW'(13)) AST_NEVER_TAKEN: assert (!hit) else $error("never code taken"); // R9
    end
endmodule

// File: rtl/bce_target_calc.sv
// Module: bce_target_calc
// Sign-extends the displacement and adds it to the PC modulo 2^AW, then clears
// bit 0. Also produces the fall-through address for a not-taken branch.
// Assumes: the displacement is a two's-complement byte offset.
module bce_target_calc
    import bce_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DISP_W,
    parameter int IB = INSTR_BYTES
) (
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] offs,
    output logic [AW-1:0] tgt,
    output logic [AW-1:0] seq
);
    localparam int EXT_W = AW - DW;

    logic [AW-1:0] offs_ext;
    logic [AW-1:0] sum;

    // Replicate the displacement sign bit up to the address width.
    always_comb begin
        offs_ext = {{EXT_W{offs[DW-1]}}, offs};
    end

    // Add the offset to the PC and clear bit 0 of the target.
    always_comb begin
        sum = pc + offs_ext;
        tgt = {sum[AW-1:1], 1'b0};
    end

    // Compute the address of the next sequential instruction.
    always_comb begin
        seq = pc + AW'(IB);
    end

    // The target must be halfword aligned.
    always_comb begin
        AST_TARGET_ALIGNED: assert (tgt[0] == 1'b0) else $error("target odd"); // R11
    end
endmodule

// File: rtl/branch_cond_eval.sv
// Module: branch_cond_eval (top)
// Evaluates the branch condition and picks the next fetch address.
// Assumes: cur_pc addresses the branch instruction itself; the block holds no state.
module branch_cond_eval
    import bce_pkg::*;
(
    input  logic [CODE_W-1:0] cond_code,
    input  logic [FLAG_W-1:0] flags,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [DISP_W-1:0] disp,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc
);
    logic              hit_w;
    logic [ADDR_W-1:0] tgt_w;
    logic [ADDR_W-1:0] seq_w;

    bce_cond_eval #(.CW(CODE_W)) u_cond (
        .code (cond_code),
        .flg  (flags),
        .hit  (hit_w)
    );

    bce_target_calc #(.AW(ADDR_W), .DW(DISP_W), .IB(INSTR_BYTES)) u_tgt (
        .pc   (cur_pc),
        .offs (disp),
        .tgt  (tgt_w),
        .seq  (seq_w)
    );

    // Drive taken and choose between the target and the fall-through address.
    always_comb begin
        taken   = hit_w;
        next_pc = hit_w ? tgt_w : seq_w;
    end

    // Check that the chosen address agrees with the taken decision.
    always_comb begin
        if (taken) AST_TAKEN_USES_TARGET: assert (next_pc == tgt_w) else $error("target not chosen"); // R10
        if (!taken) AST_FALLTHROUGH_SEQ: assert (next_pc == seq_w) else $error("fallthrough not chosen"); // R12
    end
endmodule

// File: tb/tb_branch_cond_eval.sv
module tb_branch_cond_eval;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [3:0]  cond_code;
    logic [3:0]  flags;
    logic [31:0] cur_pc;
    logic [8:0]  disp;
    logic        taken;
    logic [31:0] next_pc;
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_cond_eval dut (
        .cond_code (cond_code),
        .flags     (flags),
        .cur_pc    (cur_pc),
        .disp      (disp),
        .taken     (taken),
        .next_pc   (next_pc)
    );

    function automatic bit exp_taken(input int c, input logic [3:0] f);
        bit z, s, ov, cy, r;
        z = f[0]; s = f[1]; ov = f[2]; cy = f[3];
        case (c)
            0:  r = ov;
            1:  r = cy;
            2:  r = z;
            3:  r = (cy || z);
            4:  r = s;
            5:  r = 1;
            6:  r = (ov || s);
            7:  r = (ov != s) || z;
            8:  r = !ov;
            9:  r = !cy;
            10: r = !z;
            11: r = !cy && !z;
            12: r = !s;
            13: r = 0;
            14: r = !ov && !s;
            default: r = (ov == s) && !z;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input int c);
        case (c)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            7: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input int c, input logic [3:0] f, input logic [31:0] pc, input logic [8:0] d);
        @(negedge clk);
        cond_code = c[3:0]; flags = f; cur_pc = pc; disp = d;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        cond_code = 4'd13; flags = 4'h0; cur_pc = 32'h0000_1000; disp = 9'd0;
        apply(13, 4'h0, 32'h0000_1000, 9'd0);
        // Start-up state: the never code falls through (R9, R12).
        check("R9", {31'd0, taken}, 32'd0);
        check("R12", next_pc, 32'h0000_1002);

        // Every code against every flag pattern (R1..R9).
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                logic [31:0] exp_pc;
                bit t;
                apply(c, f[3:0], 32'h0000_4000 + 32'(c * 64), 9'h1F6);
                t = exp_taken(c, f[3:0]);
                check(tag_of(c), {31'd0, taken}, {31'd0, t});
                exp_pc = t ? (32'h0000_4000 + 32'(c * 64) - 32'd10)
                           : (32'h0000_4000 + 32'(c * 64) + 32'd2);
                check(t ? "R10" : "R12", next_pc, exp_pc);
            end
        end

        // Every displacement, taken via the always code, at two bases (R10, R11).
        for (int b = 0; b < 2; b++) begin
            for (int d = 0; d < 512; d++) begin
                logic [31:0] base, exp_t;
                int sd;
                base = (b == 0) ? 32'h0000_0080 : 32'hFFFF_FFF0;
                sd = (d >= 256) ? d - 512 : d;
                exp_t = base + 32'(sd);
                exp_t[0] = 1'b0;
                apply(5, 4'h0, base, d[8:0]);
                check((d % 2 == 1) ? "R11" : "R10", next_pc, exp_t);
            end
        end

        // Fall-through wraps at the top of the address space (R12).
        apply(13, 4'hF, 32'hFFFF_FFFE, 9'h0FF);
        check("R12", next_pc, 32'h0000_0000);
        // An odd PC with a zero displacement still gives an even target (R11).
        apply(5, 4'h0, 32'h0000_0101, 9'd0);
        check("R11", next_pc, 32'h0000_0100);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule